// File: doc/BRIEF.md
# Address Translation Unit with Translation Buffer and Page-Table Walker

This block turns 32-bit virtual addresses from a processor-side request port into 30-bit physical addresses over 1 KB pages. It first looks the virtual page number up in a small, fully associative translation buffer. On a hit it answers in the next cycle and does not touch memory. On a miss a hardware walker reads a single page-table entry through a memory read port. The entry address is the page-table base input plus four times the virtual page number. A valid entry is installed in the buffer and the translation is returned. An entry whose valid flag is clear is reported as a page fault that carries the virtual page number.

Every access carries a read/write flag. A write to a page that permits writes marks that page dirty in the buffer, and every successful response reports the page's dirty state. A write to a page that does not permit writes is refused with a protection fault. Such a refusal leaves the buffer unchanged. A flush input invalidates the whole buffer in one cycle. Only one request is outstanding at a time, so the request port is not ready while a walk is under way.

Top module: `addr_xlate_unit`

## Requirements
- R1: A successful translation returns `rsp_paddr` = {physical page number, bits 9:0 of the request address unchanged}. Bits 31:10 of the request address are the virtual page number.
- R2: A request whose page is held in the buffer is answered in the cycle after acceptance with `rsp_hit`=1, and no memory read is issued.
- R3: On a miss exactly one memory read is issued, at address `pt_base` + (virtual page number << 2). `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen, and the reply may come after any number of cycles.
- R4: A page-table entry is 32 bits: bit 31 valid, bit 30 dirty, bit 29 write permitted, bits 19:0 physical page number. When bit 31 is set, the entry is installed, so the next access to that page hits. The response comes the cycle after `mem_rsp_valid` with `rsp_hit`=0.
- R5: When bit 31 is clear, the response has `rsp_fault`=1, `rsp_fault_vpn` equal to the page number, `rsp_hit`=0 and `rsp_paddr`=0. Nothing is installed, so the next access to the page walks again.
- R6: `rsp_dirty` reports the page's dirty state after the access. A permitted write sets that state, and it stays set for later reads while the entry is held. An entry fetched with bit 30 set starts dirty.
- R7: A write to a page without write permission gives `rsp_prot_fault`=1, never together with `rsp_fault`. The refusal installs no entry and changes no dirty state, whether the page was a hit or was fetched by a walk.
- R8: While `flush` is high, `req_ready` is low. One flush cycle invalidates every buffer entry, so each page misses afterwards.
- R9: A refill takes the lowest-numbered empty entry. When all entries are occupied, the victim comes from a rotating pointer. The pointer starts at entry 0 and advances by one after each refill that used it.
- R10: `req_ready` is low from the cycle after a missing request is accepted until its response, so no second request enters during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | 30 | Physical base address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 30 | Physical address (0 on any fault) |
| rsp_hit | output | 1 | Answered from the buffer without a walk |
| rsp_dirty | output | 1 | Page dirty state after this access |
| rsp_fault | output | 1 | Page not present |
| rsp_prot_fault | output | 1 | Write to a write-protected page |
| rsp_fault_vpn | output | 22 | Virtual page number of the request |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 30 | Address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry |

## Verification
The case that is hardest to reach from the ports is eviction by the rotating pointer. That path is only taken once all eight entries hold valid translations. Its effect shows only as which later page misses. The stimulus flushes the buffer, then walks eight distinct pages and a ninth page. It then probes the pages in a chosen order, so that each probe's hit or miss, together with the count of memory reads, exposes which entry was replaced. Memory latency cycles through zero to three wait cycles on both the request and the reply sides, so the walker's hold and wait paths are covered.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   typedef enum logic [1:0] {
      WALK_IDLE  = 2'd0,
      WALK_ISSUE = 2'd1,
      WALK_WAIT  = 2'd2
   } walk_state_e;
endpackage

// File: rtl/xlt_victim.sv
module xlt_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] occupied,
   input  logic               fill,
   output logic [IDX_W-1:0]   victim
);
   logic             has_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] rr_next;

   // lowest-numbered empty slot wins
   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!occupied[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2_wrap
         assign rr_next = rr_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign rr_next = (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (fill && !has_free) begin
         rr_ptr <= rr_next;
      end
   end

   assign victim = has_free ? free_idx : rr_ptr;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 22,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_dirty,
   output logic             lk_wperm,
   input  logic             mark_dirty,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_dirty,
   input  logic             fill_wperm
);
   logic [ENTRIES-1:0] ent_vld;
   logic [ENTRIES-1:0] ent_dirty;
   logic [ENTRIES-1:0] ent_wperm;
   logic [VPN_W-1:0]   ent_tag [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   victim;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         assign match[g] = ent_vld[g] && (ent_tag[g] == lk_vpn);
      end
   endgenerate

   // tags are unique, so at most one match bit is set
   always_comb begin
      lk_idx   = '0;
      lk_ppn   = '0;
      lk_dirty = 1'b0;
      lk_wperm = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            lk_idx   = lk_idx   | IDX_W'(i);
            lk_ppn   = lk_ppn   | ent_ppn[i];
            lk_dirty = lk_dirty | ent_dirty[i];
            lk_wperm = lk_wperm | ent_wperm[i];
         end
      end
   end
   assign lk_hit = |match;

   xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .occupied (ent_vld),
      .fill     (fill_en && !flush),
      .victim   (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld   <= '0;
         ent_dirty <= '0;
         ent_wperm <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_tag[i] <= '0;
            ent_ppn[i] <= '0;
         end
      end else if (flush) begin
         ent_vld <= '0;
      end else begin
         if (mark_dirty) begin
            ent_dirty[mark_idx] <= 1'b1;
         end
         if (fill_en) begin
            ent_vld[victim]   <= 1'b1;
            ent_tag[victim]   <= fill_vpn;
            ent_ppn[victim]   <= fill_ppn;
            ent_dirty[victim] <= fill_dirty;
            ent_wperm[victim] <= fill_wperm;
         end
      end
   end
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
   import xlt_pkg::*;
#(
   parameter int VPN_W     = 22,
   parameter int PA_W      = 30,
   parameter int PTE_W     = 32,
   parameter int ENT_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VPN_W-1:0] start_vpn,
   input  logic [PA_W-1:0]  table_base,
   output logic             idle,
   output logic             done,
   output logic [PTE_W-1:0] pte,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data
);
   walk_state_e     state;
   logic [PA_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= WALK_IDLE;
         addr_q <= '0;
      end else begin
         case (state)
            WALK_IDLE: if (start) begin
               addr_q <= table_base + PA_W'({start_vpn, {ENT_SHIFT{1'b0}}});
               state  <= WALK_ISSUE;
            end
            WALK_ISSUE: if (mem_req_ready) state <= WALK_WAIT;
            WALK_WAIT:  if (mem_rsp_valid) state <= WALK_IDLE;
            default:    state <= WALK_IDLE;
         endcase
      end
   end

   assign idle          = (state == WALK_IDLE);
   assign mem_req_valid = (state == WALK_ISSUE);
   assign mem_req_addr  = addr_q;
   assign done          = (state == WALK_WAIT) && mem_rsp_valid;
   assign pte           = mem_rsp_data;
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 30,
   parameter int OFF_W       = 10,
   parameter int TLB_ENTRIES = 8,
   parameter int PTE_W       = 32,
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int PPN_W      = PA_W - OFF_W,
   localparam int IDX_W      = $clog2(TLB_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [PA_W-1:0]  pt_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_hit,
   output logic             rsp_dirty,
   output logic             rsp_fault,
   output logic             rsp_prot_fault,
   output logic [VPN_W-1:0] rsp_fault_vpn,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data
);
   localparam int PTE_V_POS = PTE_W - 1;
   localparam int PTE_D_POS = PTE_W - 2;
   localparam int PTE_W_POS = PTE_W - 3;

   generate
      if (PPN_W > PTE_W - 3) begin : g_bad_pte
         $error("physical page number does not fit beside the flag bits");
      end
      if (TLB_ENTRIES < 2) begin : g_bad_depth
         $error("translation buffer needs at least two entries");
      end
      if (VPN_W + 2 > PA_W) begin : g_bad_index
         $error("page-table index exceeds the physical address width");
      end
   endgenerate

   logic             accept;
   logic [VPN_W-1:0] req_vpn;
   logic [OFF_W-1:0] req_off;
   logic [VPN_W-1:0] vpn_q;
   logic [OFF_W-1:0] off_q;
   logic             wr_q;

   logic             lk_hit, lk_dirty, lk_wperm;
   logic [IDX_W-1:0] lk_idx;
   logic [PPN_W-1:0] lk_ppn;

   logic             wk_idle, wk_done;
   logic [PTE_W-1:0] pte;
   logic             pte_v, pte_d, pte_w;
   logic [PPN_W-1:0] pte_ppn;
   logic             pte_unused;

   logic             mark_dirty, fill_en;

   logic             nx_valid, nx_hit, nx_dirty, nx_fault, nx_prot;
   logic [PA_W-1:0]  nx_paddr;
   logic [VPN_W-1:0] nx_vpn;

   assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
   assign req_off   = req_vaddr[OFF_W-1:0];
   assign req_ready = wk_idle && !flush;
   assign accept    = req_valid && req_ready;

   assign pte_v      = pte[PTE_V_POS];
   assign pte_d      = pte[PTE_D_POS];
   assign pte_w      = pte[PTE_W_POS];
   assign pte_ppn    = pte[PPN_W-1:0];
   assign pte_unused = ^pte[PTE_W_POS-1:PPN_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q <= '0;
         off_q <= '0;
         wr_q  <= 1'b0;
      end else if (accept) begin
         vpn_q <= req_vpn;
         off_q <= req_off;
         wr_q  <= req_write;
      end
   end

   xlt_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lk_vpn     (req_vpn),
      .lk_hit     (lk_hit),
      .lk_idx     (lk_idx),
      .lk_ppn     (lk_ppn),
      .lk_dirty   (lk_dirty),
      .lk_wperm   (lk_wperm),
      .mark_dirty (mark_dirty),
      .mark_idx   (lk_idx),
      .fill_en    (fill_en),
      .fill_vpn   (vpn_q),
      .fill_ppn   (pte_ppn),
      .fill_dirty (pte_d || wr_q),
      .fill_wperm (pte_w)
   );

   xlt_walker #(
      .VPN_W     (VPN_W),
      .PA_W      (PA_W),
      .PTE_W     (PTE_W),
      .ENT_SHIFT (2)
   ) u_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (accept && !lk_hit),
      .start_vpn     (req_vpn),
      .table_base    (pt_base),
      .idle          (wk_idle),
      .done          (wk_done),
      .pte           (pte),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   assign mark_dirty = accept && lk_hit && req_write && lk_wperm;
   assign fill_en    = wk_done && pte_v && !(wr_q && !pte_w);

   always_comb begin
      nx_valid = 1'b0;
      nx_hit   = 1'b0;
      nx_dirty = 1'b0;
      nx_fault = 1'b0;
      nx_prot  = 1'b0;
      nx_paddr = '0;
      nx_vpn   = '0;
      if (accept && lk_hit) begin
         nx_valid = 1'b1;
         nx_hit   = 1'b1;
         nx_vpn   = req_vpn;
         if (req_write && !lk_wperm) begin
            nx_prot  = 1'b1;
            nx_dirty = lk_dirty;
         end else begin
            nx_paddr = {lk_ppn, req_off};
            nx_dirty = lk_dirty || req_write;
         end
      end else if (wk_done) begin
         nx_valid = 1'b1;
         nx_vpn   = vpn_q;
         if (!pte_v) begin
            nx_fault = 1'b1;
         end else if (wr_q && !pte_w) begin
            nx_prot  = 1'b1;
            nx_dirty = pte_d;
         end else begin
            nx_paddr = {pte_ppn, off_q};
            nx_dirty = pte_d || wr_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_dirty      <= 1'b0;
         rsp_fault      <= 1'b0;
         rsp_prot_fault <= 1'b0;
         rsp_paddr      <= '0;
         rsp_fault_vpn  <= '0;
      end else begin
         rsp_valid <= nx_valid;
         if (nx_valid) begin
            rsp_hit        <= nx_hit;
            rsp_dirty      <= nx_dirty;
            rsp_fault      <= nx_fault;
            rsp_prot_fault <= nx_prot;
            rsp_paddr      <= nx_paddr;
            rsp_fault_vpn  <= nx_vpn;
         end
      end
   end
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFF_W = 10,
   localparam int VPN_W = VA_W - OFF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             req_valid,
   input logic             req_ready,
   input logic [VA_W-1:0]  req_vaddr,
   input logic             rsp_valid,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic             rsp_hit,
   input logic             rsp_fault,
   input logic             rsp_prot_fault,
   input logic [VPN_W-1:0] rsp_fault_vpn,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr
);
   logic             acc;
   logic [OFF_W-1:0] off_cap;
   logic [VPN_W-1:0] vpn_cap;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_cap <= '0;
         vpn_cap <= '0;
      end else if (acc) begin
         off_cap <= req_vaddr[OFF_W-1:0];
         vpn_cap <= req_vaddr[VA_W-1:OFF_W];
      end
   end

   p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault && !rsp_prot_fault |-> rsp_paddr[OFF_W-1:0] == off_cap);

   p_hit_or_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (rsp_valid && rsp_hit) || (mem_req_valid && !rsp_valid));

   p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   p_fault_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> !rsp_hit && rsp_paddr == '0 && rsp_fault_vpn == vpn_cap);

   p_single_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_fault && rsp_prot_fault));

   p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !req_ready);

   p_walk_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);
endmodule

bind addr_xlate_unit xlt_checker #(
   .VA_W  (VA_W),
   .PA_W  (PA_W),
   .OFF_W (OFF_W)
) u_chk (.*);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
   localparam logic [29:0] BASE = 30'h0200_0000;

   typedef struct {
      logic        hit;
      logic        fault;
      logic        prot;
      logic        dirty;
      logic [29:0] paddr;
      logic [21:0] vpn;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        req_ready, rsp_valid, rsp_hit, rsp_dirty, rsp_fault, rsp_prot_fault;
   logic [29:0] rsp_paddr, mem_req_addr;
   logic [21:0] rsp_fault_vpn;
   logic        mem_req_valid;

   int          n_checks = 0;
   int          n_fail = 0;
   int          n_reads = 0;
   logic [21:0] cur_vpn = '0;
   logic [31:0] ptab [int];
   exp_t        exp_q [$];

   always #2 clk = ~clk;

   addr_xlate_unit u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_fault(rsp_fault),
      .rsp_prot_fault(rsp_prot_fault), .rsp_fault_vpn(rsp_fault_vpn),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] pte_of(int vpn);
      return ptab.exists(vpn) ? ptab[vpn] : 32'h0;
   endfunction

   // R4 layout: bit31 valid, bit30 dirty, bit29 write permitted, bits19:0 ppn
   function automatic logic [31:0] mk_pte(logic v, logic d, logic w, logic [19:0] ppn);
      return {v, d, w, 9'b0, ppn};
   endfunction

   task automatic check(logic ok, string msg, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   // memory model with rotating latency; checks the entry address (R3)
   initial begin
      int lat = 0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [29:0] a;
            repeat (lat) @(negedge clk);
            a = mem_req_addr;
            check(a == BASE + {6'b0, cur_vpn, 2'b00}, "R3 entry address", 64'(a),
                  64'(BASE + {6'b0, cur_vpn, 2'b00}));
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pte_of(int'((a - BASE) >> 2));
            n_reads++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            lat = (lat + 1) % 4;
         end
      end
   end

   // monitor: pops expected responses
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected response", 64'(rsp_paddr), 64'h0);
         end else begin
            exp_t e;
            logic ok;
            e  = exp_q.pop_front();
            ok = (rsp_hit == e.hit) && (rsp_fault == e.fault) && (rsp_prot_fault == e.prot);
            if (!e.fault && !e.prot) ok = ok && (rsp_paddr == e.paddr) && (rsp_dirty == e.dirty);
            if (e.fault) ok = ok && (rsp_fault_vpn == e.vpn) && (rsp_paddr == '0);
            check(ok, e.tag,
                  {rsp_hit, rsp_fault, rsp_prot_fault, rsp_dirty, rsp_paddr},
                  {e.hit, e.fault, e.prot, e.dirty, e.paddr});
         end
      end
   end

   task automatic do_req(int vpn, int off, logic wr, logic e_hit, logic e_fault,
                         logic e_prot, logic e_dirty, string tag);
      exp_t e;
      int   reads0;
      e.hit   = e_hit;
      e.fault = e_fault;
      e.prot  = e_prot;
      e.dirty = e_dirty;
      e.paddr = {pte_of(vpn)[19:0], 10'(off)};
      e.vpn   = 22'(vpn);
      e.tag   = tag;
      exp_q.push_back(e);
      reads0  = n_reads;
      cur_vpn = 22'(vpn);
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = {22'(vpn), 10'(off)};
      req_write = wr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!e_hit) check(req_ready == 1'b0, {"R10 ready during walk ", tag}, 64'(req_ready), 64'h0);
      wait (exp_q.size() == 0);
      @(negedge clk);
      check(n_reads == reads0 + (e_hit ? 0 : 1), {"R2 memory reads ", tag},
            64'(n_reads - reads0), 64'(e_hit ? 0 : 1));
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      #1;
      check(req_ready == 1'b0, "R8 ready low during flush", 64'(req_ready), 64'h0);
      @(negedge clk);
      flush = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      ptab[22'h00123] = mk_pte(1, 0, 1, 20'hABCDE);
      ptab[22'h00200] = mk_pte(0, 0, 1, 20'h11111);
      ptab[22'h00300] = mk_pte(1, 0, 0, 20'h22222);
      ptab[22'h00400] = mk_pte(1, 1, 1, 20'h33333);
      for (int i = 0; i < 9; i++) ptab[22'h100 + i] = mk_pte(1, 0, 1, 20'(20'h500 + i));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
            {req_ready, rsp_valid, mem_req_valid}, 3'b100);

      do_req(22'h123, 10'h3FF, 0, 0, 0, 0, 0, "R4 miss refill");
      do_req(22'h123, 10'h001, 0, 1, 0, 0, 0, "R2 hit after refill R1");
      do_req(22'h123, 10'h2A5, 1, 1, 0, 0, 1, "R6 write marks dirty");
      do_req(22'h123, 10'h000, 0, 1, 0, 0, 1, "R6 dirty kept on read");
      do_req(22'h200, 10'h010, 0, 0, 1, 0, 0, "R5 page fault");
      do_req(22'h200, 10'h010, 0, 0, 1, 0, 0, "R5 fault not installed");
      do_req(22'h300, 10'h020, 1, 0, 0, 1, 0, "R7 protection on walk");
      do_req(22'h300, 10'h020, 0, 0, 0, 0, 0, "R7 no refill after refusal");
      do_req(22'h300, 10'h021, 1, 1, 0, 1, 0, "R7 protection on hit");
      do_req(22'h300, 10'h022, 0, 1, 0, 0, 0, "R7 dirty unchanged");
      do_req(22'h400, 10'h155, 0, 0, 0, 0, 1, "R6 fetched dirty");

      do_flush();
      do_req(22'h123, 10'h004, 0, 0, 0, 0, 0, "R8 miss after flush");

      do_flush();
      for (int i = 0; i < 8; i++) do_req(22'h100 + i, i, 0, 0, 0, 0, 0, "R9 fill empty");
      for (int i = 0; i < 8; i++) do_req(22'h100 + i, i, 0, 1, 0, 0, 0, "R9 all held");
      do_req(22'h108, 10'h008, 0, 0, 0, 0, 0, "R9 evict entry0");
      do_req(22'h103, 10'h003, 0, 1, 0, 0, 0, "R9 entry3 kept");
      do_req(22'h100, 10'h000, 0, 0, 0, 0, 0, "R9 entry0 gone");
      do_req(22'h101, 10'h001, 0, 0, 0, 0, 0, "R9 entry1 rotated out");
      do_req(22'h104, 10'h004, 0, 1, 0, 0, 0, "R9 entry4 kept");
      do_req(22'h108, 10'h3C0, 0, 1, 0, 0, 0, "R9 newest held R1");

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule